// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block holds the register set and the control engine of one bus-master DMA channel that sits beside a SCSI protocol core in a host adapter. Software programs a start byte count, a start memory address and a start descriptor-list address, then issues a command. A start command copies the three start values into working copies, clears the status bits and enables the channel. From then on the transfer-request port asks to move data. Each request carries a length and a direction. The channel grants at most the bytes still remaining, moves the working address forward and counts the working byte count down. It flags completion when the count reaches zero.

Status has its own clearing rules. An external control input picks one of two modes. In the first, software clears sticky bits by writing ones to them. In the second, status writes do nothing and each status read clears the sticky bits after returning them. The SCSI core is modelled by two inputs: an interrupt level that shows in the status read value, and a command-complete pulse that empties the working count. An abort command sends a one-cycle cancel pulse toward the core.

Register access uses a 3-bit word index. Writes take effect at the clock edge. Read data is registered and appears on the cycle after the read strobe.

Top module: `scsi_dma_chan`

## Requirements
- R1: Synchronous reset sets command, start count, start address, start descriptor address, working count and status to 0. It sets the working address to 0xFFFFFFFF and the working descriptor address to 0xFFFFFFFD. It also drops chan_en, cancel_strobe and xfer_ready.
- R2: The word index selects 0 = command, 1 = start count, 2 = start address, 3 = working count, 4 = working address, 5 = status, 6 = start descriptor address and 7 = working descriptor address. Indices 0, 1, 2 and 6 read back the value last written. Read data appears on reg_rdata one cycle after reg_rd_en.
- R3: Writes to indices 3, 4 and 7 leave those registers unchanged.
- R4: Command bits [1:0] select 0 = idle, 1 = blast, 2 = abort and 3 = start. Command bit 7 selects the direction, where 1 means device to memory.
  - A start command copies start count, start address and start descriptor address into their working copies. It clears status bits 0 to 5 and sets chan_en on the next cycle.
  - An idle command clears chan_en on the next cycle.
- R5: An abort command makes cancel_strobe high for exactly one cycle, starting the cycle after the write.
- R6: A status read returns bit 4 set whenever core_irq is high at the read. The stored status is not changed by core_irq.
- R7: With clr_on_read low, a status write clears only those of status bits 1 (error), 2 (abort) and 3 (done) that are written as 1.
- R8: With clr_on_read high, status writes have no effect. A status read returns the stored value and then clears bits 1 to 3.
- R9: A transfer request whose direction differs from command bit 7 is answered with a grant of 0. The working count, the working address and status do not change.
- R10: A transfer request in the matching direction is granted the lesser of its length and the working count. The working count falls by the grant and the working address rises by it. Status bit 3 (done) is set when the working count reaches zero.
- R11: A cmd_done pulse forces the working count to zero and sets status bit 3.
- R12: A request is accepted while xfer_valid is high and xfer_ready is low. xfer_ready then pulses for one cycle, the cycle after acceptance, with the grant on xfer_grant_len. xfer_grant_len is 0 whenever xfer_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| clr_on_read | input | 1 | Status clear mode: 1 = clear on read, 0 = write one to clear |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| cmd_done | input | 1 | SCSI command completion pulse |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_dir | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | 32 | Requested byte count |
| xfer_ready | output | 1 | Request answered (one-cycle pulse) |
| xfer_grant_len | output | 32 | Granted byte count, valid with xfer_ready |
| chan_en | output | 1 | Channel enabled level |
| cancel_strobe | output | 1 | One-cycle cancel toward the SCSI core |

## Verification
Some rules are checked on every cycle:
- the cancel pulse is one cycle wide and follows each abort write;
- chan_en follows start and idle commands;
- xfer_ready never stays high for two cycles, and the grant is zero outside it;
- no grant exceeds the count left before it;
- the working count only falls between start commands and is zero after cmd_done;
- reset restores the working address.

Other behaviour shows only in the bench scenarios:
- the contents of the snapshot copies;
- the clamping and zero-reach sequence over several transfers;
- direction mismatches leaving the registers untouched;
- the interrupt bit in status reads;
- the two status clearing modes, which need a read or write followed by a later read.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD   = 3'd0,
    IX_SCNT  = 3'd1,
    IX_SADR  = 3'd2,
    IX_WCNT  = 3'd3,
    IX_WADR  = 3'd4,
    IX_STAT  = 3'd5,
    IX_SDSC  = 3'd6,
    IX_WDSC  = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } cmd_op_e;

  localparam int CMD_DIR_BIT = 7;

  localparam int ST_W       = 6;
  localparam int ST_ERR     = 1;
  localparam int ST_ABT     = 2;
  localparam int ST_DONE    = 3;
  localparam int ST_IRQ     = 4;
  localparam logic [ST_W-1:0] ST_STICKY = 6'b00_1110;
endpackage

// File: rtl/dma_cmd_ctl.sv
module dma_cmd_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic              start_p,
  output logic              dir,
  output logic              chan_en,
  output logic              cancel_strobe
);
  import scsi_dma_pkg::*;

  cmd_op_e op;
  assign op      = cmd_op_e'(wdata[1:0]);
  assign start_p = cmd_wr && (op == OP_START);
  assign dir     = cmd_q[CMD_DIR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q         <= '0;
      chan_en       <= 1'b0;
      cancel_strobe <= 1'b0;
    end else begin
      cancel_strobe <= cmd_wr && (op == OP_ABORT);
      if (cmd_wr) begin
        cmd_q <= wdata;
        case (op)
          OP_START: chan_en <= 1'b1;
          OP_IDLE:  chan_en <= 1'b0;
          default:  chan_en <= chan_en;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_progress.sv
module dma_progress #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] WADR_RST = '1,
  parameter logic [DATA_W-1:0] WDSC_RST = {{(DATA_W-2){1'b1}}, 2'b01}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              dir,
  input  logic [DATA_W-1:0] scnt,
  input  logic [DATA_W-1:0] sadr,
  input  logic [DATA_W-1:0] sdsc,
  input  logic              cmd_done,
  input  logic              xfer_valid,
  input  logic              xfer_dir,
  input  logic [DATA_W-1:0] xfer_len,
  output logic              xfer_ready,
  output logic [DATA_W-1:0] xfer_grant_len,
  output logic [DATA_W-1:0] wcnt,
  output logic [DATA_W-1:0] wadr,
  output logic [DATA_W-1:0] wdsc,
  output logic              done_set
);
  logic              accept;
  logic              match;
  logic [DATA_W-1:0] grant;
  logic [DATA_W-1:0] left;

  assign accept = xfer_valid && !xfer_ready;
  assign match  = (xfer_dir == dir);
  assign grant  = !match ? '0 : ((xfer_len < wcnt) ? xfer_len : wcnt);
  assign left   = wcnt - grant;

  assign done_set = !start_p &&
                    (cmd_done || (accept && match && (left == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt           <= '0;
      wadr           <= WADR_RST;
      wdsc           <= WDSC_RST;
      xfer_ready     <= 1'b0;
      xfer_grant_len <= '0;
    end else begin
      xfer_ready     <= accept;
      xfer_grant_len <= accept ? grant : '0;
      if (start_p) begin
        wcnt <= scnt;
        wadr <= sadr;
        wdsc <= sdsc;
      end else if (cmd_done) begin
        wcnt <= '0;
      end else if (accept && match) begin
        wcnt <= left;
        wadr <= wadr + grant;
      end
    end
  end
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg
  import scsi_dma_pkg::*;
#(
  parameter int W = ST_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_p,
  input  logic         stat_wr,
  input  logic         stat_rd,
  input  logic         clr_on_read,
  input  logic [W-1:0] wbits,
  input  logic         done_set,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (start_p) begin
      nxt = '0;
    end else begin
      if (stat_wr && !clr_on_read) nxt = nxt & ~(wbits & ST_STICKY);
      if (stat_rd && clr_on_read)  nxt = nxt & ~ST_STICKY;
      if (done_set)                nxt[ST_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter logic [DATA_W-1:0] WADR_RST = '1,
  parameter logic [DATA_W-1:0] WDSC_RST = {{(DATA_W-2){1'b1}}, 2'b01}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              clr_on_read,
  input  logic              core_irq,
  input  logic              cmd_done,
  input  logic              xfer_valid,
  input  logic              xfer_dir,
  input  logic [DATA_W-1:0] xfer_len,
  output logic              xfer_ready,
  output logic [DATA_W-1:0] xfer_grant_len,
  output logic              chan_en,
  output logic              cancel_strobe
);
  import scsi_dma_pkg::*;

  localparam int NREG = 1 << IDX_W;

  logic [DATA_W-1:0] cmd_q, scnt, sadr, sdsc, wcount, waddr, wdsc;
  logic [ST_W-1:0]   stat_q;
  logic              start_p, dir, done_set;
  logic [NREG-1:0]   wr_sel;
  logic [DATA_W-1:0] rd_view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = reg_wr_en && (reg_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt <= '0;
      sadr <= '0;
      sdsc <= '0;
    end else begin
      if (wr_sel[IX_SCNT]) scnt <= reg_wdata;
      if (wr_sel[IX_SADR]) sadr <= reg_wdata;
      if (wr_sel[IX_SDSC]) sdsc <= reg_wdata;
    end
  end

  dma_cmd_ctl #(.DATA_W(DATA_W)) u_cmd (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (wr_sel[IX_CMD]),
    .wdata         (reg_wdata),
    .cmd_q         (cmd_q),
    .start_p       (start_p),
    .dir           (dir),
    .chan_en       (chan_en),
    .cancel_strobe (cancel_strobe)
  );

  dma_progress #(
    .DATA_W   (DATA_W),
    .WADR_RST (WADR_RST),
    .WDSC_RST (WDSC_RST)
  ) u_prog (
    .clk            (clk),
    .rst            (rst),
    .start_p        (start_p),
    .dir            (dir),
    .scnt           (scnt),
    .sadr           (sadr),
    .sdsc           (sdsc),
    .cmd_done       (cmd_done),
    .xfer_valid     (xfer_valid),
    .xfer_dir       (xfer_dir),
    .xfer_len       (xfer_len),
    .xfer_ready     (xfer_ready),
    .xfer_grant_len (xfer_grant_len),
    .wcnt           (wcount),
    .wadr           (waddr),
    .wdsc           (wdsc),
    .done_set       (done_set)
  );

  dma_status_reg #(.W(ST_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .start_p     (start_p),
    .stat_wr     (wr_sel[IX_STAT]),
    .stat_rd     (reg_rd_en && (reg_idx == IX_STAT)),
    .clr_on_read (clr_on_read),
    .wbits       (reg_wdata[ST_W-1:0]),
    .done_set    (done_set),
    .stat_q      (stat_q)
  );

  always_comb begin
    rd_view[IX_CMD]  = cmd_q;
    rd_view[IX_SCNT] = scnt;
    rd_view[IX_SADR] = sadr;
    rd_view[IX_WCNT] = wcount;
    rd_view[IX_WADR] = waddr;
    rd_view[IX_STAT] = DATA_W'(stat_q | (ST_W'(core_irq) << ST_IRQ));
    rd_view[IX_SDSC] = sdsc;
    rd_view[IX_WDSC] = wdsc;
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_view[reg_idx];
  end
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter logic [DATA_W-1:0] WADR_RST = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              cmd_done,
  input logic              xfer_ready,
  input logic [DATA_W-1:0] xfer_grant_len,
  input logic              chan_en,
  input logic              cancel_strobe,
  input logic [DATA_W-1:0] wcount,
  input logic [DATA_W-1:0] waddr
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_en && (reg_idx == '0);

  // R5: the cancel pulse is one cycle wide
  p_cancel_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    cancel_strobe |=> !cancel_strobe);
  // R5: each abort write produces a cancel pulse
  p_abort_cancels_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[1:0] == 2'd2) |=> cancel_strobe);
  // R4: a start command enables the channel
  p_start_enables_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[1:0] == 2'd3) |=> chan_en);
  // R4: an idle command disables the channel
  p_idle_disables_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[1:0] == 2'd0) |=> !chan_en);
  // R12: xfer_ready is never high on two consecutive cycles
  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_ready |=> !xfer_ready);
  // R12: the grant is zero while xfer_ready is low
  p_grant_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !xfer_ready |-> (xfer_grant_len == '0));
  // R10: a grant never exceeds the count left before it
  p_grant_bound_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_ready |-> (xfer_grant_len <= $past(wcount)));
  // R10: without a start command the working count never grows
  p_count_no_grow_r10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && reg_wdata[1:0] == 2'd3) |=> (wcount <= $past(wcount)));
  // R11: cmd_done empties the working count
  p_done_empties_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !(cmd_wr && reg_wdata[1:0] == 2'd3)) |=> (wcount == '0));
  // R1: reset restores the working address and drops chan_en
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (waddr == WADR_RST && !chan_en && !cancel_strobe));
endmodule

bind scsi_dma_chan dma_chan_checker #(
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W),
  .WADR_RST (WADR_RST)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_wr_en      (reg_wr_en),
  .reg_idx        (reg_idx),
  .reg_wdata      (reg_wdata),
  .cmd_done       (cmd_done),
  .xfer_ready     (xfer_ready),
  .xfer_grant_len (xfer_grant_len),
  .chan_en        (chan_en),
  .cancel_strobe  (cancel_strobe),
  .wcount         (wcount),
  .waddr          (waddr)
);

// File: tb/tb_scsi_dma_chan.sv
`timescale 1ns/1ps
module tb_scsi_dma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clr_on_read = 1'b0, core_irq = 1'b0, cmd_done = 1'b0;
  logic        xfer_valid = 1'b0, xfer_dir = 1'b0;
  logic [31:0] xfer_len = '0;
  logic        xfer_ready;
  logic [31:0] xfer_grant_len;
  logic        chan_en, cancel_strobe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scsi_dma_chan dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_on_read(clr_on_read), .core_irq(core_irq), .cmd_done(cmd_done),
    .xfer_valid(xfer_valid), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
    .xfer_ready(xfer_ready), .xfer_grant_len(xfer_grant_len),
    .chan_en(chan_en), .cancel_strobe(cancel_strobe)
  );

  // dir(1) len(16) grant(16) count_after(16) addr_after(32) done(1)
  localparam logic [81:0] VEC [0:4] = '{
    {1'b0, 16'd30, 16'd30, 16'd70, 32'h0000_101E, 1'b0},
    {1'b1, 16'd10, 16'd0,  16'd70, 32'h0000_101E, 1'b0},
    {1'b0, 16'd0,  16'd0,  16'd70, 32'h0000_101E, 1'b0},
    {1'b0, 16'd50, 16'd50, 16'd20, 32'h0000_1050, 1'b0},
    {1'b0, 16'd40, 16'd20, 16'd0,  32'h0000_1064, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic xfer(logic dir, logic [31:0] len, output logic [31:0] g);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_dir = dir; xfer_len = len;
    @(negedge clk);
    while (!xfer_ready) @(negedge clk);
    g = xfer_grant_len;
    xfer_valid = 1'b0;
    @(negedge clk);
    check("R12 ready drops", {31'd0, xfer_ready}, 32'd0);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, g;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 chan_en", {31'd0, chan_en}, 32'd0);
    check("R1 cancel", {31'd0, cancel_strobe}, 32'd0);
    check("R1 ready", {31'd0, xfer_ready}, 32'd0);
    rd(3'd0, v); check("R1 cmd", v, 32'd0);
    rd(3'd3, v); check("R1 wcount", v, 32'd0);
    rd(3'd4, v); check("R1 waddr", v, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R1 status", v, 32'd0);
    rd(3'd7, v); check("R1 wdesc", v, 32'hFFFF_FFFD);

    // R2 start registers read back
    wr(3'd1, 32'd100);
    wr(3'd2, 32'h0000_1000);
    wr(3'd6, 32'h0000_2000);
    rd(3'd1, v); check("R2 start count", v, 32'd100);
    rd(3'd2, v); check("R2 start addr", v, 32'h0000_1000);
    rd(3'd6, v); check("R2 start desc", v, 32'h0000_2000);

    // R3 working registers ignore writes
    wr(3'd3, 32'h1234_5678);
    wr(3'd4, 32'h1234_5678);
    wr(3'd7, 32'h1234_5678);
    rd(3'd3, v); check("R3 wcount", v, 32'd0);
    rd(3'd4, v); check("R3 waddr", v, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R3 wdesc", v, 32'hFFFF_FFFD);

    // R4 start command, direction memory to device (bit7 = 0)
    wr(3'd0, 32'h0000_0003);
    check("R4 chan_en on start", {31'd0, chan_en}, 32'd1);
    rd(3'd0, v); check("R2 cmd readback", v, 32'h0000_0003);
    rd(3'd3, v); check("R4 wcount copy", v, 32'd100);
    rd(3'd4, v); check("R4 waddr copy", v, 32'h0000_1000);
    rd(3'd7, v); check("R4 wdesc copy", v, 32'h0000_2000);

    // R9 / R10 vector table
    for (int i = 0; i < 5; i++) begin
      xfer(VEC[i][81], {16'd0, VEC[i][80:65]}, g);
      check(VEC[i][81] ? "R9 grant" : "R10 grant", g, {16'd0, VEC[i][64:49]});
      rd(3'd3, v); check("R10 wcount", v, {16'd0, VEC[i][48:33]});
      rd(3'd4, v); check("R10 waddr", v, VEC[i][32:1]);
      rd(3'd5, v); check("R10 done bit", v, {28'd0, VEC[i][0], 3'd0});
    end

    // R7 write-one-to-clear
    wr(3'd5, 32'h0000_0000);
    rd(3'd5, v); check("R7 zero write keeps", v, 32'h8);
    wr(3'd5, 32'h0000_0008);
    rd(3'd5, v); check("R7 one clears done", v, 32'h0);

    // R6 SCSI interrupt visible in status read
    core_irq = 1'b1;
    rd(3'd5, v); check("R6 irq bit", v, 32'h10);
    core_irq = 1'b0;
    rd(3'd5, v); check("R6 irq not stored", v, 32'h0);

    // R5 abort
    wr(3'd0, 32'h0000_0002);
    check("R5 cancel high", {31'd0, cancel_strobe}, 32'd1);
    @(negedge clk);
    check("R5 cancel one cycle", {31'd0, cancel_strobe}, 32'd0);

    // R4 restart clears status, R11 cmd_done
    wr(3'd1, 32'd64);
    wr(3'd0, 32'h0000_0003);
    rd(3'd3, v); check("R4 restart count", v, 32'd64);
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    rd(3'd3, v); check("R11 count zero", v, 32'd0);
    rd(3'd5, v); check("R11 done set", v, 32'h8);

    // R8 clear-on-read
    clr_on_read = 1'b1;
    wr(3'd5, 32'h0000_0008);
    rd(3'd5, v); check("R8 write ignored", v, 32'h8);
    rd(3'd5, v); check("R8 read cleared", v, 32'h0);
    clr_on_read = 1'b0;

    // R4 start clears status after done
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    wr(3'd0, 32'h0000_0083);
    rd(3'd5, v); check("R4 start clears status", v, 32'h0);
    xfer(1'b1, 32'd5, g); check("R10 dir bit7 grant", g, 32'd5);

    // R4 idle
    wr(3'd0, 32'h0000_0000);
    check("R4 idle disables", {31'd0, chan_en}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule